// File: doc/BRIEF.md
# Core Standby Gate Controller

This block decides when a processor core may stop its clocks and when it must start them again. A one-cycle pulse tells it that a wait instruction has reached the write-back stage. If the system bus is idle in that same cycle and no wake source is active, the block moves to a standby state. It then drops the core clock enable, which drives an external clock-gating cell, and raises a standby flag. If the bus is busy, the wait does nothing beyond its interrupt-enable side effect, and the core keeps running.

The block runs on the ungated clock, so it stays live while the core is frozen. The wake sources are six external interrupt lines, the non-maskable interrupt, the external bus request, the free-running timer interrupt, and the warm and cold reset pins. While the block is in standby, any one of them returns it to the running state. The clock enable comes back on the edge that samples the wake, and the core resumes where it stopped. Every wait pulse seen while the block is running also produces a one-cycle pulse that tells the core to set its interrupt enable.

Top module: `stby_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are `core_clk_en`=1, `standby`=0 and `ie_set`=0.
- R2: A `wait_wb` pulse with `bus_idle`=1 and no active wake source, while running, makes `standby`=1 and `core_clk_en`=0 from the next clock edge.
- R3: A `wait_wb` pulse with `bus_idle`=0 leaves the block running: `standby` stays 0 and `core_clk_en` stays 1.
- R4: Each `wait_wb` pulse accepted while running gives `ie_set`=1 for exactly the following cycle, whether or not the bus is idle.
- R5: In standby with no wake source active, `standby` stays 1 and `core_clk_en` stays 0 for as many cycles as that lasts.
- R6: In standby, any bit of `wake_irq` set to 1 brings back `core_clk_en`=1 and `standby`=0 one clock edge after it is sampled.
- R7: In standby, `wake_timer`=1 wakes the block in the same way as R6.
- R8: In standby, `wake_nmi`=1 or `wake_ext_req`=1 wakes the block in the same way as R6.
- R9: In standby, `wake_warm_rst`=1 or `wake_cold_rst`=1 returns the block to running on the next edge.
- R10: If any wake source is active in the same cycle as an idle-bus `wait_wb`, the block does not enter standby. `ie_set` still pulses.
- R11: `standby` is always the inverse of `core_clk_en`.
- R12: A `wait_wb` pulse that arrives while in standby is ignored: no `ie_set` pulse and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_wb | input | 1 | Wait instruction has reached write-back (one-cycle pulse) |
| bus_idle | input | 1 | System bus is idle |
| wake_irq | input | 6 | External interrupt lines, active high |
| wake_nmi | input | 1 | Non-maskable interrupt |
| wake_ext_req | input | 1 | External bus request |
| wake_timer | input | 1 | Internal timer interrupt |
| wake_warm_rst | input | 1 | Warm reset pin seen as a wake source |
| wake_cold_rst | input | 1 | Cold reset pin seen as a wake source |
| core_clk_en | output | 1 | Enable for the core clock-gating cell |
| standby | output | 1 | High while in standby |
| ie_set | output | 1 | One-cycle request to set the interrupt enable |

## Verification
The bench issues a wait pulse against a busy bus; a design that ignores the bus status would stop the clock there. It raises a wake source in the very cycle of an idle-bus wait; a design that lacks the collision rule would enter standby and then sit with the clock off, or lose that wake entirely. Each wake source, including the timer and both reset pins, is tried on its own; a design that leaves one of them out of the wake merge would never release the core. The bench also checks that `ie_set` pulses for both accepted and dropped waits, and that a stray wait pulse during standby gives no pulse.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [0:0] {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } stby_state_t;
endpackage

// File: rtl/stby_wake_or.sv
module stby_wake_or #(
  parameter int N_IRQ = 6
) (
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             nmi_i,
  input  logic             ext_req_i,
  input  logic             timer_i,
  input  logic             warm_rst_i,
  input  logic             cold_rst_i,
  output logic             wake_o,
  output logic             rst_wake_o
);
  localparam int N_SRC = N_IRQ + 4;

  logic [N_SRC-1:0] src;

  genvar g;
  generate
    for (g = 0; g < N_IRQ; g++) begin : g_irq
      assign src[g] = irq_i[g];
    end
  endgenerate

  assign src[N_IRQ]     = nmi_i;
  assign src[N_IRQ + 1] = ext_req_i;
  assign src[N_IRQ + 2] = timer_i;
  assign src[N_IRQ + 3] = warm_rst_i | cold_rst_i;

  assign rst_wake_o = warm_rst_i | cold_rst_i;
  assign wake_o     = |src;
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wait_i,
  input  logic idle_i,
  input  logic wake_i,
  input  logic rst_wake_i,
  output logic clk_en_o,
  output logic sleep_o,
  output logic ie_set_o
);
  stby_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (wait_i && idle_i && !wake_i) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_i || rst_wake_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_RUN;
      clk_en_o <= 1'b1;
      ie_set_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      clk_en_o <= (state_d == ST_RUN);
      ie_set_o <= wait_i && (state_q == ST_RUN);
    end
  end

  assign sleep_o = (state_q == ST_SLEEP);

  a_r11_flag_vs_en: assert property (@(posedge clk) disable iff (rst)
    sleep_o != clk_en_o);

  a_r2_enter: assert property (@(posedge clk) disable iff (rst)
    (!sleep_o && wait_i && idle_i && !wake_i) |=> (sleep_o && !clk_en_o));

  a_r3_busy_stays: assert property (@(posedge clk) disable iff (rst)
    (!sleep_o && !idle_i) |=> clk_en_o);

  a_r10_collision: assert property (@(posedge clk) disable iff (rst)
    (!sleep_o && wake_i) |=> !sleep_o);

  a_r6_wake_exit: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && wake_i) |=> (clk_en_o && !sleep_o));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && !wake_i && !rst_wake_i) |=> sleep_o);

  a_r4_ie_pulse: assert property (@(posedge clk) disable iff (rst)
    (!sleep_o && wait_i) |=> ie_set_o);

  a_r12_ignored: assert property (@(posedge clk) disable iff (rst)
    (sleep_o && wait_i) |=> !ie_set_o);
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
  parameter int N_IRQ = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_wb,
  input  logic             bus_idle,
  input  logic [N_IRQ-1:0] wake_irq,
  input  logic             wake_nmi,
  input  logic             wake_ext_req,
  input  logic             wake_timer,
  input  logic             wake_warm_rst,
  input  logic             wake_cold_rst,
  output logic             core_clk_en,
  output logic             standby,
  output logic             ie_set
);
  logic wake_any;
  logic wake_rst;

  stby_wake_or #(.N_IRQ(N_IRQ)) u_wake (
    .irq_i      (wake_irq),
    .nmi_i      (wake_nmi),
    .ext_req_i  (wake_ext_req),
    .timer_i    (wake_timer),
    .warm_rst_i (wake_warm_rst),
    .cold_rst_i (wake_cold_rst),
    .wake_o     (wake_any),
    .rst_wake_o (wake_rst)
  );

  stby_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wait_i     (wait_wb),
    .idle_i     (bus_idle),
    .wake_i     (wake_any),
    .rst_wake_i (wake_rst),
    .clk_en_o   (core_clk_en),
    .sleep_o    (standby),
    .ie_set_o   (ie_set)
  );
endmodule

// File: tb/stby_ctrl_tb_top.sv
module stby_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_wb = 1'b0, bus_idle = 1'b1;
  logic [5:0] wake_irq = '0;
  logic wake_nmi = 1'b0, wake_ext_req = 1'b0, wake_timer = 1'b0;
  logic wake_warm_rst = 1'b0, wake_cold_rst = 1'b0;
  logic core_clk_en, standby, ie_set;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stby_ctrl dut_i (
    .clk(clk), .rst(rst), .wait_wb(wait_wb), .bus_idle(bus_idle),
    .wake_irq(wake_irq), .wake_nmi(wake_nmi), .wake_ext_req(wake_ext_req),
    .wake_timer(wake_timer), .wake_warm_rst(wake_warm_rst),
    .wake_cold_rst(wake_cold_rst), .core_clk_en(core_clk_en),
    .standby(standby), .ie_set(ie_set)
  );

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_run(string req);
    check(req, "standby", standby, 1'b0);
    check(req, "core_clk_en", core_clk_en, 1'b1);
  endtask

  task automatic check_sleep(string req);
    check(req, "standby", standby, 1'b1);
    check(req, "core_clk_en", core_clk_en, 1'b0);
  endtask

  // one-cycle wait pulse; returns sampled after the capturing edge
  task automatic pulse_wait(logic idle);
    @(negedge clk);
    wait_wb = 1'b1; bus_idle = idle;
    @(negedge clk);
    wait_wb = 1'b0; bus_idle = 1'b1;
  endtask

  task automatic go_sleep(string req);
    pulse_wait(1'b1);
    check_sleep(req);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "core_clk_en", core_clk_en, 1'b1);
    check("R1", "standby", standby, 1'b0);
    check("R1", "ie_set", ie_set, 1'b0);
  endtask

  task automatic t_enter;
    pulse_wait(1'b1);
    check_sleep("R2");
    check("R4", "ie_set", ie_set, 1'b1);
    check("R11", "inverse", standby, ~core_clk_en);
    @(negedge clk);
    check("R4", "ie_set single", ie_set, 1'b0);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 8; i++) @(negedge clk);
    check_sleep("R5");
  endtask

  task automatic t_wait_in_sleep;
    pulse_wait(1'b1);
    check("R12", "ie_set", ie_set, 1'b0);
    check_sleep("R12");
  endtask

  task automatic t_irq;
    for (int b = 0; b < 6; b++) begin
      @(negedge clk); wake_irq[b] = 1'b1;
      @(negedge clk); wake_irq[b] = 1'b0;
      check_run("R6");
      go_sleep("R2");
    end
  endtask

  task automatic t_timer;
    @(negedge clk); wake_timer = 1'b1;
    @(negedge clk); wake_timer = 1'b0;
    check_run("R7");
    go_sleep("R2");
  endtask

  task automatic t_nmi_ext;
    @(negedge clk); wake_nmi = 1'b1;
    @(negedge clk); wake_nmi = 1'b0;
    check_run("R8");
    go_sleep("R2");
    @(negedge clk); wake_ext_req = 1'b1;
    @(negedge clk); wake_ext_req = 1'b0;
    check_run("R8");
    go_sleep("R2");
  endtask

  task automatic t_resets;
    @(negedge clk); wake_warm_rst = 1'b1;
    @(negedge clk); wake_warm_rst = 1'b0;
    check_run("R9");
    go_sleep("R2");
    @(negedge clk); wake_cold_rst = 1'b1;
    @(negedge clk); wake_cold_rst = 1'b0;
    check_run("R9");
  endtask

  task automatic t_busy;
    pulse_wait(1'b0);
    check_run("R3");
    check("R4", "ie_set on dropped wait", ie_set, 1'b1);
    @(negedge clk);
    check_run("R3");
    check("R4", "ie_set single", ie_set, 1'b0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    wait_wb = 1'b1; bus_idle = 1'b1; wake_timer = 1'b1;
    @(negedge clk);
    wait_wb = 1'b0; wake_timer = 1'b0;
    check_run("R10");
    check("R10", "ie_set", ie_set, 1'b1);
    @(negedge clk);
    wait_wb = 1'b1; wake_irq[2] = 1'b1;
    @(negedge clk);
    wait_wb = 1'b0; wake_irq[2] = 1'b0;
    check_run("R10");
    @(negedge clk);
    check_run("R10");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_busy();
    t_enter();
    t_hold();
    t_wait_in_sleep();
    t_irq();
    t_timer();
    t_nmi_ext();
    t_resets();
    t_collision();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule